// File: doc/BRIEF.md
# Banked MSI Interrupt Controller

This block gathers message-signalled interrupts for a root port. Up to `NUM_BANKS` groups of 32 vectors are kept, and each group has three words: an enable word, a mask word and a status word. An incoming MSI carries a target address and a vector number. The block accepts it only when the address equals the 64-bit capture address that software has programmed. The upper bits of the vector number select the group, and the low five bits select the bit inside it. The status bit is set only when the matching enable bit is set.

Software reaches every word through a simple register bus. Each write is a one-cycle strobe. A read returns its data one cycle after the strobe. A separate pending window gives one read per group. That read returns the status bits that are not masked and clears exactly those bits. A single level interrupt output is high while any group holds a status bit that is both enabled and unmasked.

Top module: `msi_bank_ctrl`

## Requirements
- R1: Group k has its enable word at byte address 12k, its mask word at 12k+4 and its status word at 12k+8. Every read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the `bus_rd` strobe.
- R2: After reset, every enable word is 0, every mask word is all ones, every status word is 0, both capture words are 0, and `irq` and `bus_rvalid` are low.
- R3: An MSI whose address matches the capture address sets status bit `v[4:0]` of group `v[7:5]` when that bit is enabled. Here v is `msi_vector`.
- R4: An MSI to a vector whose enable bit is clear leaves every status word unchanged.
- R5: An MSI whose address differs from the capture address leaves every status word unchanged.
- R6: A write to a status word clears each bit written as 1. Bits written as 0 keep their value.
- R7: A write to an enable word clears the mask bit of every bit that changes from 0 to 1. Mask bits of bits that were already enabled keep their value.
- R8: A read at 0x100+4k returns group k's status AND NOT mask, and clears those bits. Masked status bits remain set.
- R9: `irq` is high exactly when some group has a bit that is set in status and enable and clear in mask. It follows that state in the cycle after the state changes.
- R10: When an MSI sets a status bit in the same cycle that a clear targets the same bit, the bit ends up set.
- R11: The lower capture word is at 0x200 and the upper capture word is at 0x204. Both can be written and read back.
- R12: A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| msi_valid | input | 1 | An MSI memory write is presented |
| msi_addr | input | 64 | Target address of the MSI |
| msi_vector | input | VEC_W | Vector number carried by the MSI |
| irq | output | 1 | Combined interrupt level |

## Verification
The MSI path is driven with three kinds of write. The first is a vector that is enabled and arrives at the matching address. The second is a vector that is not enabled, at the matching address. The third is an enabled vector at an address that differs in a single bit. These separate the enable gate from the address comparator. Vectors are placed in the lowest and highest bit positions of both low and high groups, so a swap of group-select and bit-select fields shows up at once. Pending reads are done with the status bit masked and then unmasked, which tells the mask filter apart from the clear-on-read. Enable writes are made with bits that are new and bits that were already set, which separates the automatic unmask from a plain mask overwrite.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned LANE_W      = 5;
    localparam int unsigned BANK_STRIDE = 12;
    localparam int unsigned MSI_ADDR_W  = 64;

    localparam logic [ADDR_W-1:0] PEND_BASE   = 12'h100;
    localparam logic [ADDR_W-1:0] CAP_LO_ADDR = 12'h200;
    localparam logic [ADDR_W-1:0] CAP_HI_ADDR = 12'h204;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } bank_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
    } bus_req_t;

    typedef struct packed {
        logic  hit;
        word_t data;
    } rd_resp_t;

    function automatic bank_sel_e decode_bank(input logic [ADDR_W-1:0] addr,
                                              input int unsigned idx);
        logic [ADDR_W-1:0] base;
        base = ADDR_W'(idx * BANK_STRIDE);
        if (addr == base)                     return SEL_ENABLE;
        else if (addr == base + ADDR_W'(4))   return SEL_MASK;
        else if (addr == base + ADDR_W'(8))   return SEL_STATUS;
        else                                  return SEL_NONE;
    endfunction

    function automatic logic [ADDR_W-1:0] pend_addr(input int unsigned idx);
        return PEND_BASE + ADDR_W'(idx * 4);
    endfunction

endpackage

// File: rtl/msi_ingress.sv
module msi_ingress
    import msi_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    localparam int unsigned BANK_SEL_W = $clog2(NUM_BANKS),
    localparam int unsigned VEC_W = BANK_SEL_W + LANE_W
) (
    input  logic                         msi_valid,
    input  logic [MSI_ADDR_W-1:0]        msi_addr,
    input  logic [VEC_W-1:0]             msi_vector,
    input  word_t                        cap_lo,
    input  word_t                        cap_hi,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] set_hits
);

    logic addr_match;
    logic [BANK_SEL_W-1:0] bank_sel;
    logic [LANE_W-1:0]     lane_sel;

    assign addr_match = msi_valid && (msi_addr == {cap_hi, cap_lo});
    assign bank_sel   = msi_vector[VEC_W-1:LANE_W];
    assign lane_sel   = msi_vector[LANE_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        always_comb begin
            set_hits[b] = '0;
            if (addr_match && (bank_sel == BANK_SEL_W'(b))) begin
                set_hits[b][lane_sel] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/msi_capture_regs.sv
module msi_capture_regs
    import msi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output word_t    cap_lo,
    output word_t    cap_hi,
    output rd_resp_t resp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lo <= '0;
            cap_hi <= '0;
        end else if (req.wr) begin
            if (req.addr == CAP_LO_ADDR) cap_lo <= req.wdata;
            if (req.addr == CAP_HI_ADDR) cap_hi <= req.wdata;
        end
    end

    always_comb begin
        resp = '0;
        if (req.rd && req.addr == CAP_LO_ADDR) begin
            resp.hit  = 1'b1;
            resp.data = cap_lo;
        end else if (req.rd && req.addr == CAP_HI_ADDR) begin
            resp.hit  = 1'b1;
            resp.data = cap_hi;
        end
    end

endmodule

// File: rtl/msi_bank.sv
module msi_bank
    import msi_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  word_t    set_hit,
    output word_t    en_o,
    output word_t    mask_o,
    output word_t    stat_o,
    output rd_resp_t resp,
    output logic     irq_o
);

    localparam logic [ADDR_W-1:0] MY_PEND = pend_addr(IDX);

    word_t     en_q, mask_q, stat_q;
    word_t     en_d, mask_d, stat_d;
    word_t     set_ok, clr_w1c, clr_pend, visible;
    bank_sel_e sel;
    logic      pend_hit;

    assign sel      = decode_bank(req.addr, IDX);
    assign pend_hit = req.rd && (req.addr == MY_PEND);
    assign visible  = stat_q & ~mask_q;

    // an MSI only lands on a bit whose enable is already set
    assign set_ok   = set_hit & en_q;
    assign clr_w1c  = (req.wr && sel == SEL_STATUS) ? req.wdata : '0;
    assign clr_pend = pend_hit ? visible : '0;

    always_comb begin
        en_d   = en_q;
        mask_d = mask_q;
        if (req.wr && sel == SEL_ENABLE) begin
            en_d   = req.wdata;
            mask_d = mask_q & ~(req.wdata & ~en_q);
        end else if (req.wr && sel == SEL_MASK) begin
            mask_d = req.wdata;
        end
        // set is applied after the clears so it wins on a collision
        stat_d = (stat_q & ~(clr_w1c | clr_pend)) | set_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '1;
            stat_q <= '0;
        end else begin
            en_q   <= en_d;
            mask_q <= mask_d;
            stat_q <= stat_d;
        end
    end

    always_comb begin
        resp = '0;
        if (pend_hit) begin
            resp.hit  = 1'b1;
            resp.data = visible;
        end else if (req.rd) begin
            unique case (sel)
                SEL_ENABLE: begin resp.hit = 1'b1; resp.data = en_q;   end
                SEL_MASK:   begin resp.hit = 1'b1; resp.data = mask_q; end
                SEL_STATUS: begin resp.hit = 1'b1; resp.data = stat_q; end
                default:    resp = '0;
            endcase
        end
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & en_q & ~mask_q);

endmodule

// File: rtl/msi_bank_ctrl.sv
module msi_bank_ctrl
    import msi_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    localparam int unsigned VEC_W = $clog2(NUM_BANKS) + LANE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  msi_valid,
    input  logic [MSI_ADDR_W-1:0] msi_addr,
    input  logic [VEC_W-1:0]      msi_vector,
    output logic                  irq
);

    bus_req_t req;
    word_t    cap_lo, cap_hi;
    rd_resp_t cap_resp;
    rd_resp_t bank_resp [NUM_BANKS];
    logic [NUM_BANKS-1:0]             bank_irq;
    logic [NUM_BANKS-1:0][WORD_W-1:0] set_hits;
    logic [NUM_BANKS-1:0][WORD_W-1:0] en_all, mask_all, stat_all;
    word_t    rd_word;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    msi_capture_regs u_cap (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .resp   (cap_resp)
    );

    msi_ingress #(.NUM_BANKS(NUM_BANKS)) u_ingress (
        .msi_valid  (msi_valid),
        .msi_addr   (msi_addr),
        .msi_vector (msi_vector),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi),
        .set_hits   (set_hits)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        msi_bank #(.IDX(b)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .req     (req),
            .set_hit (set_hits[b]),
            .en_o    (en_all[b]),
            .mask_o  (mask_all[b]),
            .stat_o  (stat_all[b]),
            .resp    (bank_resp[b]),
            .irq_o   (bank_irq[b])
        );
    end

    // decodes are disjoint, so an OR of the gated words is the mux
    always_comb begin
        rd_word = cap_resp.hit ? cap_resp.data : '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_resp[b].hit) rd_word = rd_word | bank_resp[b].data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_word;
        end
    end

    assign irq = |bank_irq;

endmodule

// File: rtl/msi_bank_ctrl_chk.sv
module msi_bank_ctrl_chk
    import msi_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             bus_rd,
    input logic                             bus_rvalid,
    input logic                             msi_valid,
    input logic                             irq,
    input logic [NUM_BANKS-1:0][WORD_W-1:0] en_all,
    input logic [NUM_BANKS-1:0][WORD_W-1:0] mask_all,
    input logic [NUM_BANKS-1:0][WORD_W-1:0] stat_all
);

    p_read_latency_r1: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|stat_all));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_reset_state_r2: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (en_all[b] == '0 && mask_all[b] == '1 && stat_all[b] == '0));

        p_set_only_enabled_r4: assert property (@(posedge clk) disable iff (rst)
            ((stat_all[b] & ~$past(stat_all[b]) & ~$past(en_all[b])) == '0));

        p_set_needs_msi_r3: assert property (@(posedge clk) disable iff (rst)
            ((stat_all[b] & ~$past(stat_all[b])) != '0) |-> $past(msi_valid));

        p_enable_unmasks_r7: assert property (@(posedge clk) disable iff (rst)
            ((en_all[b] & ~$past(en_all[b]) & mask_all[b]) == '0));
    end

endmodule

bind msi_bank_ctrl msi_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/msi_bank_ctrl_tb.sv
module msi_bank_ctrl_tb;

    typedef enum logic [1:0] {OP_WR, OP_RD, OP_MSI, OP_MSI_BAD} op_e;

    typedef struct packed {
        op_e         op;
        logic [7:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam logic [31:0] CAP_LO = 32'hFEE0_0040;
    localparam int NV = 30;

    // requirement tags per entry: R11 R2 R7 R3 R4 R5 R8 R6 R12 R1
    localparam vec_t TABLE [NV] = '{
        '{OP_WR,      8'd11, 12'h200, CAP_LO,        32'h0},
        '{OP_RD,      8'd11, 12'h200, 32'h0,         CAP_LO},
        '{OP_RD,      8'd11, 12'h204, 32'h0,         32'h0},
        '{OP_RD,      8'd2,  12'h000, 32'h0,         32'h0},
        '{OP_RD,      8'd2,  12'h004, 32'h0,         32'hFFFF_FFFF},
        '{OP_WR,      8'd7,  12'h000, 32'h0000_0005, 32'h0},
        '{OP_RD,      8'd7,  12'h004, 32'h0,         32'hFFFF_FFFA},
        '{OP_MSI,     8'd3,  12'h000, 32'd2,         32'h0},
        '{OP_MSI,     8'd4,  12'h000, 32'd1,         32'h0},
        '{OP_RD,      8'd3,  12'h008, 32'h0,         32'h0000_0004},
        '{OP_MSI_BAD, 8'd5,  12'h000, 32'd0,         32'h0},
        '{OP_RD,      8'd5,  12'h008, 32'h0,         32'h0000_0004},
        '{OP_WR,      8'd3,  12'h03C, 32'h8000_0000, 32'h0},
        '{OP_MSI,     8'd3,  12'h000, 32'hBF,        32'h0},
        '{OP_RD,      8'd3,  12'h044, 32'h0,         32'h8000_0000},
        '{OP_WR,      8'd8,  12'h040, 32'hFFFF_FFFF, 32'h0},
        '{OP_RD,      8'd8,  12'h114, 32'h0,         32'h0},
        '{OP_RD,      8'd8,  12'h044, 32'h0,         32'h8000_0000},
        '{OP_WR,      8'd8,  12'h040, 32'h0,         32'h0},
        '{OP_RD,      8'd8,  12'h114, 32'h0,         32'h8000_0000},
        '{OP_RD,      8'd8,  12'h044, 32'h0,         32'h0},
        '{OP_WR,      8'd6,  12'h008, 32'h0,         32'h0},
        '{OP_RD,      8'd6,  12'h008, 32'h0,         32'h0000_0004},
        '{OP_WR,      8'd6,  12'h008, 32'h0000_0004, 32'h0},
        '{OP_RD,      8'd6,  12'h008, 32'h0,         32'h0},
        '{OP_RD,      8'd12, 12'h300, 32'h0,         32'h0},
        '{OP_WR,      8'd7,  12'h004, 32'hFFFF_FFFF, 32'h0},
        '{OP_WR,      8'd7,  12'h000, 32'h0000_0007, 32'h0},
        '{OP_RD,      8'd7,  12'h004, 32'h0,         32'hFFFF_FFFD},
        '{OP_RD,      8'd1,  12'h054, 32'h0,         32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [7:0]  msi_vector = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    msi_bank_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .msi_valid  (msi_valid),
        .msi_addr   (msi_addr),
        .msi_vector (msi_vector),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_msi(input logic [7:0] v, input logic good);
        msi_valid = 1'b1; msi_vector = v;
        msi_addr = good ? {32'h0, CAP_LO} : {32'h0, CAP_LO ^ 32'h4};
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: outputs idle after reset
        check("R2 irq", {31'h0, irq}, 32'h0);
        check("R2 rvalid", {31'h0, bus_rvalid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (TABLE[i].op)
                OP_WR:      do_wr(TABLE[i].addr, TABLE[i].data);
                OP_MSI:     do_msi(TABLE[i].data[7:0], 1'b1);
                OP_MSI_BAD: do_msi(TABLE[i].data[7:0], 1'b0);
                default: begin
                    do_rd(TABLE[i].addr, rd);
                    check($sformatf("R%0d row %0d", TABLE[i].req, i), rd, TABLE[i].exp);
                end
            endcase
        end

        // R1: rvalid high exactly one cycle after the strobe
        bus_rd = 1'b1; bus_addr = 12'h000;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R1 rvalid", {31'h0, bus_rvalid}, 32'h1);
        @(negedge clk);
        check("R1 rvalid drop", {31'h0, bus_rvalid}, 32'h0);

        // R10: MSI set and W1C of bank 0 bit 0 in the same cycle
        do_msi(8'd0, 1'b1);
        bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h1;
        msi_valid = 1'b1; msi_vector = 8'd0; msi_addr = {32'h0, CAP_LO};
        @(negedge clk);
        bus_wr = 1'b0; msi_valid = 1'b0;
        do_rd(12'h008, rd);
        check("R10 set wins", rd, 32'h1);
        do_wr(12'h008, 32'h1);

        // R9: bank 7 bit 0 is vector 0xE0
        check("R9 idle", {31'h0, irq}, 32'h0);
        do_wr(12'h054, 32'h1);
        do_msi(8'hE0, 1'b1);
        check("R9 raised", {31'h0, irq}, 32'h1);
        do_wr(12'h058, 32'h1);
        check("R9 masked", {31'h0, irq}, 32'h0);
        do_wr(12'h058, 32'h0);
        check("R9 unmasked", {31'h0, irq}, 32'h1);
        do_wr(12'h05C, 32'h1);
        check("R9 cleared", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule